// File: doc/BRIEF.md
# Converter Input Slot Sequencer

This block shares one analog-to-digital converter among four input slots per frame. A frame starts on a pulse from the computation engine. The block steps through slots 0 to 3. For each slot it places a source code on the mux select, issues a one-cycle conversion request and waits for the converter's result on a valid/ready stream. It then writes that result to a result-memory address fixed by the source, using a second valid/ready stream.

A host may ask for an alternate frame, normally about once per second. In an alternate frame, slot 0 samples the temperature sensor and slot 2 samples the supply monitor, in place of the two voltage inputs. Slots 1 and 3 keep their current inputs. Each auxiliary result goes to its own address. Right after it, the block rewrites the skipped voltage's address with the last voltage sample taken in a regular frame. Downstream logic therefore always finds a full set of voltage and current values.

The block runs on the slow sequencer clock. The converter takes two of those cycles per result. Back-pressure rules:
- The result stream is accepted only in the cycle where `res_valid` and `res_ready` are both high.
- `res_ready` is high only while a conversion is outstanding.
- On the write stream, `mem_addr` and `mem_data` stay stable while `mem_valid` is high and `mem_ready` is low.
- The next conversion is not requested until the current slot's last write is accepted.

Top module: `adc_mux_sequencer`

## Requirements
- R1: After reset, `conv_req`, `res_ready`, `mem_valid`, `frame_done` and `overrun` are all low, and no conversion is requested until a start pulse.
- R2: A regular frame selects source codes 0, 1, 2, 3 (inputs A0..A3) in that order, with exactly one `conv_req` pulse per slot.
- R3: Each converter result is written exactly once to address `BASE_ADDR + source code`, with the data unchanged.
- R4: An alternate frame selects source codes 4 (temperature), 1 (A1), 5 (supply monitor) and 3 (A3), in that order.
- R5: In an alternate frame, the temperature write is followed by a write of the held A0 sample to `BASE_ADDR + 0`. The supply write is followed by a write of the held A2 sample to `BASE_ADDR + 2`. The held values are the most recent regular-frame A0/A2 results, or zero if no regular frame has run yet.
- R6: An alternate request is latched and applies to the next accepted start. A request in the same cycle as an accepted start applies to that frame. One request yields exactly one alternate frame.
- R7: A start pulse that arrives while a frame is running launches nothing. It sets `overrun`, which stays high until reset. A start in the `frame_done` cycle is accepted normally.
- R8: `frame_done` is high for exactly one cycle: the cycle after the slot-3 write is accepted, and at no other time.
- R9: While `mem_valid` is high and `mem_ready` is low, address and data hold. `res_ready` stays high until a result is accepted. A request, a result wait and a write never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame launch pulse from the computation engine |
| alt_req | input | 1 | Alternate-frame request pulse from the host |
| mux_sel | output | 3 | Source code: 0-3 inputs A0-A3, 4 temperature, 5 supply monitor |
| conv_req | output | 1 | One-cycle conversion request |
| res_valid | input | 1 | Converter result valid |
| res_ready | output | 1 | Block can take a result |
| res_data | input | DATA_W | Converter result |
| mem_valid | output | 1 | Result-memory write valid |
| mem_ready | input | 1 | Result memory accepts write |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| overrun | output | 1 | Sticky flag: start seen while busy |

## Verification
Two events can land in the same cycle: the end-of-frame pulse and the next start pulse. The bench raises a start in the very cycle `frame_done` is seen. It then judges that the new frame runs in full and that `overrun` stays low. A second coincidence is an alternate request arriving with the start that it must govern. The bench verifies that the frame it launches writes the auxiliary sources plus the backfilled voltage values, in the expected order and at the expected addresses.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int SLOTS  = 4;
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int SRC_W  = 3;
  localparam int HELD   = SLOTS / 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_A0     = 3'd0,
    SRC_A1     = 3'd1,
    SRC_A2     = 3'd2,
    SRC_A3     = 3'd3,
    SRC_TEMP   = 3'd4,
    SRC_SUPPLY = 3'd5
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT,
    ST_WR_MAIN,
    ST_WR_FILL
  } st_e;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              alt_req,
  input  logic              res_valid,
  input  logic              mem_ready,
  output st_e               state,
  output logic [SLOT_W-1:0] slot,
  output logic              alt_active,
  output logic              take,
  output logic              frame_done,
  output logic              overrun
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic alt_pending;
  logic slot_end;

  assign take = (state == ST_WAIT) && res_valid;

  // the current slot is finished when its final write is accepted
  always_comb begin
    slot_end = 1'b0;
    if (mem_ready) begin
      if (state == ST_WR_FILL) slot_end = 1'b1;
      else if (state == ST_WR_MAIN) slot_end = !(alt_active && !slot[0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      slot        <= '0;
      alt_active  <= 1'b0;
      alt_pending <= 1'b0;
      frame_done  <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (state == ST_IDLE) begin
        if (frame_start) begin
          alt_active  <= alt_pending | alt_req;
          alt_pending <= 1'b0;
          slot        <= '0;
          state       <= ST_CONV;
        end else if (alt_req) begin
          alt_pending <= 1'b1;
        end
      end else begin
        if (alt_req)     alt_pending <= 1'b1;
        if (frame_start) overrun     <= 1'b1;
        unique case (state)
          ST_CONV: state <= ST_WAIT;
          ST_WAIT: if (take) state <= ST_WR_MAIN;
          ST_WR_MAIN: if (mem_ready && !slot_end) state <= ST_WR_FILL;
          default: ;
        endcase
        if (slot_end) begin
          if (slot == LAST_SLOT) begin
            state      <= ST_IDLE;
            frame_done <= 1'b1;
          end else begin
            slot  <= slot + 1'b1;
            state <= ST_CONV;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adcseq_hold.sv
module adcseq_hold
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              alt_active,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] res_data,
  output logic [DATA_W-1:0] sample,
  output logic [DATA_W-1:0] fill_data
);
  logic [DATA_W-1:0] held [HELD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample <= '0;
    else if (take) sample <= res_data;
  end

  // one backup register per even (voltage) slot, refreshed only by regular frames
  for (genvar g = 0; g < HELD; g++) begin : g_held
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(2 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held[g] <= '0;
      else if (take && !alt_active && slot == MY_SLOT) held[g] <= res_data;
    end
  end

  assign fill_data = held[slot[SLOT_W-1:1]];
endmodule

// File: rtl/adcseq_route.sv
module adcseq_route
  import adcseq_pkg::*;
#(
  parameter int                DATA_W    = 22,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  st_e               state,
  input  logic [SLOT_W-1:0] slot,
  input  logic              alt_active,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] fill_data,
  output logic [SRC_W-1:0]  mux_sel,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  src_e src;
  logic fill;

  always_comb begin
    src = src_e'(SRC_W'(slot));
    if (alt_active && !slot[0]) src = slot[1] ? SRC_SUPPLY : SRC_TEMP;
  end

  assign fill     = (state == ST_WR_FILL);
  assign mux_sel  = src;
  assign mem_addr = BASE_ADDR + (fill ? ADDR_W'(slot) : ADDR_W'(src));
  assign mem_data = fill ? fill_data : sample;
endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
  import adcseq_pkg::*;
#(
  parameter int                DATA_W    = 22,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              alt_req,
  output logic [2:0]        mux_sel,
  output logic              conv_req,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [DATA_W-1:0] res_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              frame_done,
  output logic              overrun
);
  st_e               state;
  logic [SLOT_W-1:0] slot;
  logic              alt_active;
  logic              take;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] fill_data;

  adcseq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .alt_req    (alt_req),
    .res_valid  (res_valid),
    .mem_ready  (mem_ready),
    .state      (state),
    .slot       (slot),
    .alt_active (alt_active),
    .take       (take),
    .frame_done (frame_done),
    .overrun    (overrun)
  );

  adcseq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .alt_active(alt_active),
    .slot      (slot),
    .res_data  (res_data),
    .sample    (sample),
    .fill_data (fill_data)
  );

  adcseq_route #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_route (
    .state     (state),
    .slot      (slot),
    .alt_active(alt_active),
    .sample    (sample),
    .fill_data (fill_data),
    .mux_sel   (mux_sel),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data)
  );

  assign conv_req  = (state == ST_CONV);
  assign res_ready = (state == ST_WAIT);
  assign mem_valid = (state == ST_WR_MAIN) || (state == ST_WR_FILL);
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int                DATA_W    = 22,
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 6'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mux_sel,
  input logic              conv_req,
  input logic              res_valid,
  input logic              res_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic              frame_done,
  input logic              overrun
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(3);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> $past(mem_valid && mem_ready) && $past(mem_addr) == LAST_ADDR);

  assert_write_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_ready_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready && !res_valid |=> res_ready);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({conv_req, res_ready, mem_valid}) <= 1);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req && res_ready);

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> mux_sel <= 3'd5);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind adc_mux_sequencer adcseq_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_check (
  .clk       (clk),
  .rst_n     (rst_n),
  .mux_sel   (mux_sel),
  .conv_req  (conv_req),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_data  (mem_data),
  .frame_done(frame_done),
  .overrun   (overrun)
);

// File: tb/test_adc_mux_sequencer.sv
module test_adc_mux_sequencer;
  localparam int DW = 22;
  localparam int AW = 6;
  localparam logic [AW-1:0] BASE = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, alt_req = 1'b0;
  logic res_valid = 1'b0, mem_ready = 1'b1;
  logic [DW-1:0] res_data = '0;
  logic [2:0] mux_sel;
  logic conv_req, res_ready, mem_valid, frame_done, overrun;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  adc_mux_sequencer i_adc_mux_sequencer (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .alt_req(alt_req),
    .mux_sel(mux_sel), .conv_req(conv_req), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .frame_done(frame_done), .overrun(overrun)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int frame_no = 0, cyc = 0, conv_cnt = 0, conv_sel = 0, req_seen = 0;
  bit stall = 1'b0, hs = 1'b0, done_exp = 1'b0;
  logic [DW-1:0] last_a0 = '0, last_a2 = '0;

  typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; string req; } wr_t;
  wr_t exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dval(input int f, input int s);
    return DW'((f << 8) | (s << 4) | 5);
  endfunction

  task automatic push(input int a, input logic [DW-1:0] d, input string req);
    wr_t e;
    e.a = AW'(a); e.d = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // converter model: result two cycles after each request, data tags frame and source
  always @(posedge clk) begin
    hs = res_valid && res_ready;
    #1;
    if (hs) res_valid = 1'b0;
    if (conv_req) begin
      conv_cnt = 2;
      conv_sel = int'(mux_sel);
    end else if (conv_cnt > 0) begin
      conv_cnt--;
      if (conv_cnt == 0) begin
        res_valid = 1'b1;
        res_data  = dval(frame_no, conv_sel);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    #2 mem_ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (conv_req) req_seen++;
      if (frame_done || done_exp)
        check(frame_done == done_exp, "R8", "frame_done", frame_done, done_exp);
      done_exp = 1'b0;
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected write addr", mem_addr, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.a, e.req, "write addr", mem_addr, e.a);
          check(mem_data == e.d, e.req, "write data", mem_data, e.d);
        end
        done_exp = (mem_addr == BASE + AW'(3));
      end
    end
  end

  task automatic wait_done();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (frame_done) return;
    end
    check(1'b0, "R8", "frame_done never seen", 0, 1);
  endtask

  task automatic run_frame(input bit alt_exp, input bit req_with_start,
                           input bit start_on_done, input bit mid_alt, input bit mid_start);
    int f;
    frame_no++;
    f = frame_no;
    if (alt_exp) begin
      push(BASE + 4, dval(f, 4), "R4");
      push(BASE + 0, last_a0,    "R5");
      push(BASE + 1, dval(f, 1), "R4");
      push(BASE + 5, dval(f, 5), "R4");
      push(BASE + 2, last_a2,    "R5");
      push(BASE + 3, dval(f, 3), "R4");
    end else begin
      for (int s = 0; s < 4; s++) push(BASE + s, dval(f, s), "R2");
      last_a0 = dval(f, 0);
      last_a2 = dval(f, 2);
    end
    if (!start_on_done) begin
      @(posedge clk);
      #1;
    end
    frame_start = 1'b1;
    alt_req     = req_with_start;
    @(posedge clk);
    #1 frame_start = 1'b0;
    alt_req = 1'b0;
    if (mid_alt) begin
      repeat (5) @(posedge clk);
      #1 alt_req = 1'b1;
      @(posedge clk);
      #1 alt_req = 1'b0;
    end
    if (mid_start) begin
      repeat (8) @(posedge clk);
      #1 frame_start = 1'b1;
      @(posedge clk);
      #1 frame_start = 1'b0;
    end
    wait_done();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!conv_req,   "R1", "conv_req in reset",   conv_req, 0);
    check(!res_ready,  "R1", "res_ready in reset",  res_ready, 0);
    check(!mem_valid,  "R1", "mem_valid in reset",  mem_valid, 0);
    check(!frame_done, "R1", "frame_done in reset", frame_done, 0);
    check(!overrun,    "R1", "overrun in reset",    overrun, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(req_seen == 0, "R1", "request without start", req_seen, 0);

    // R6 R5: request with start -> alternate frame, backfill zero before any regular frame
    run_frame(1, 1, 0, 0, 0);
    // R2 R3: plain regular frame
    run_frame(0, 0, 0, 0, 0);
    // R9: regular frame under write back-pressure
    stall = 1'b1;
    run_frame(0, 0, 0, 0, 0);
    stall = 1'b0;
    // R6: mid-frame request does not alter the running frame
    run_frame(0, 0, 0, 1, 0);
    // R6 R7: start in the frame_done cycle, latched request applies now
    run_frame(1, 0, 1, 0, 0);
    check(!overrun, "R7", "start on done flagged overrun", overrun, 0);
    // R6: request is one-shot
    run_frame(0, 0, 0, 0, 0);
    // R5 R9: alternate frame under back-pressure
    stall = 1'b1;
    run_frame(1, 1, 0, 0, 0);
    stall = 1'b0;
    // R7: start while busy is ignored and flagged
    run_frame(0, 0, 0, 0, 1);
    check(overrun, "R7", "overrun after busy start", overrun, 1);
    req_seen = 0;
    repeat (30) @(negedge clk);
    check(req_seen == 0, "R7", "ignored start launched frame", req_seen, 0);
    run_frame(0, 0, 0, 0, 0);
    check(overrun, "R7", "overrun not sticky", overrun, 1);
    check(exp_q.size() == 0, "R3", "writes missing", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule